// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Controller

This block turns twelve general-purpose input pins into edge-sensitive interrupt sources. Each source has a polarity fixed at build time. Seven sources respond only to a low-to-high change. The other five respond only to a high-to-low change. Every pin first passes through a two-stage synchroniser. It then feeds a small per-source level tracker. The tracker has two named states, `LVL_LOW` and `LVL_HIGH`, and it follows the synchronised level. The transitions are `LVL_LOW -> LVL_HIGH` (the level rose) and `LVL_HIGH -> LVL_LOW` (the level fell). A tracker emits a one-cycle strobe when it takes the transition that matches its polarity. If the per-pin edge-enable input is high in that cycle, the strobe sets the source's sticky flag.

Software uses a narrow write port. With select 0 it clears the flags at the positions of the 1 bits in the write data. With select 1 it loads the enable mask. The flags and the enable mask are visible on outputs. A single request line is high when some source has both its flag and its enable set, provided the processor's interrupt-disable bit is low. Flags keep recording edges while interrupts are disabled.

Top module: `edge_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `flags`, `irq_mask` and `irq_req` are all 0.
- R2: A rising source (a 1 bit in polarity mask 12'h733, i.e. indices 0, 1, 4, 5, 8, 9, 10) sets its flag bit on a 0-to-1 pin change. The flag is seen high after the third rising clock edge that follows the change, and is still low after the second. A 1-to-0 change leaves the flag unchanged.
- R3: A falling source (a 0 bit in 12'h733, i.e. indices 2, 3, 6, 7, 11) sets its flag bit on a 1-to-0 pin change, with the same latency as R2. A 0-to-1 change leaves the flag unchanged.
- R4: A flag is set by a one-cycle strobe, not by the pin level. After the flag is cleared, a pin held at its post-edge level does not set the flag again.
- R5: An edge on a source whose `edge_en` bit is 0 does not set its flag. Raising `edge_en` later, while the pin level is steady, does not set it either.
- R6: With `cpu_iflag` low, `irq_req` is 1 exactly when `flags & irq_mask` is non-zero.
- R7: While `cpu_iflag` is 1, `irq_req` is 0, yet qualifying edges still set flags.
- R8: A write with `wr_sel`=0 clears each flag bit whose `wr_data` bit is 1 and leaves the other flag bits unchanged.
- R9: A write with `wr_sel`=1 loads `wr_data` into `irq_mask` on the next clock edge and leaves `flags` unchanged.
- R10: If a qualifying edge strobe and a clear of the same flag bit fall in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 12 | Asynchronous pin levels |
| edge_en | input | 12 | Per-pin edge-interrupt enable from bus configuration |
| cpu_iflag | input | 1 | Processor interrupt-disable bit (1 = masked) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = clear flags, 1 = load enable mask |
| wr_data | input | 12 | Write data |
| flags | output | 12 | Interrupt flag register |
| irq_mask | output | 12 | Interrupt enable register |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The assertions check four things on every cycle. The request stays low while the disable bit is set, and it is never high without an enabled flag. A flag rises only where its edge enable was high, and it falls only through a clear write at that bit. An accepted strobe always leaves its flag set, even under a simultaneous clear, and enable writes land one cycle later. The polarity of each source, the three-cycle latency, and the fact that held levels and opposite edges are ignored can only be shown by the bench. It sweeps every source in both directions and computes the expected flag word from the polarity mask.

// File: rtl/eifc_pkg.sv
package eifc_pkg;
    localparam int unsigned NSRC_DEF = 12;
    localparam logic [11:0] RISE_DEF = 12'h733;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_t;

    typedef enum logic {
        SEL_FLAG_CLR = 1'b0,
        SEL_ENABLE   = 1'b1
    } wr_sel_t;
endpackage

// File: rtl/eifc_sync.sv
module eifc_sync #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/eifc_edge_fsm.sv
module eifc_edge_fsm
    import eifc_pkg::*;
#(
    parameter logic RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic arm,
    output logic fire
);
    lvl_state_t state, state_nx;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            LVL_LOW:  if (lvl)  state_nx = LVL_HIGH;
            LVL_HIGH: if (!lvl) state_nx = LVL_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LVL_LOW;
        else        state <= state_nx;
    end

    // one-shot output on the qualifying transition only
    always_comb begin
        fire = 1'b0;
        unique case (state)
            LVL_LOW:  fire = arm && RISING && lvl;
            LVL_HIGH: fire = arm && !RISING && !lvl;
        endcase
    end
endmodule

// File: rtl/eifc_flag_bank.sv
module eifc_flag_bank #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_we,
    input  logic         ena_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flag_q,
    output logic [W-1:0] ena_q
);
    logic [W-1:0] clr_vec;

    assign clr_vec = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            ena_q  <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_vec) | set_vec;
            if (ena_we) ena_q <= wdata;
        end
    end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import eifc_pkg::*;
#(
    parameter int unsigned NSRC      = NSRC_DEF,
    parameter logic [NSRC-1:0] RISE_MASK = RISE_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pin_in,
    input  logic [NSRC-1:0] edge_en,
    input  logic            cpu_iflag,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [NSRC-1:0] wr_data,
    output logic [NSRC-1:0] flags,
    output logic [NSRC-1:0] irq_mask,
    output logic            irq_req
);
    logic [NSRC-1:0] pin_s;
    logic [NSRC-1:0] set_vec;
    logic            clr_we;
    logic            ena_we;

    eifc_sync #(.W(NSRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        eifc_edge_fsm #(.RISING(RISE_MASK[i])) u_fsm (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (pin_s[i]),
            .arm   (edge_en[i]),
            .fire  (set_vec[i])
        );
    end

    assign clr_we = wr_en && (wr_sel == SEL_FLAG_CLR);
    assign ena_we = wr_en && (wr_sel == SEL_ENABLE);

    eifc_flag_bank #(.W(NSRC)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_we  (clr_we),
        .ena_we  (ena_we),
        .wdata   (wr_data),
        .flag_q  (flags),
        .ena_q   (irq_mask)
    );

    assign irq_req = !cpu_iflag && |(flags & irq_mask);
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk #(
    parameter int unsigned NSRC = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] edge_en,
    input logic            cpu_iflag,
    input logic            wr_en,
    input logic            wr_sel,
    input logic [NSRC-1:0] wr_data,
    input logic [NSRC-1:0] flags,
    input logic [NSRC-1:0] irq_mask,
    input logic            irq_req,
    input logic [NSRC-1:0] set_vec
);
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_iflag |-> !irq_req); // R7

    AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (|(flags & irq_mask))); // R6

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (irq_mask == $past(wr_data))); // R9

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        AST_RISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[i]) |-> $past(edge_en[i])); // R5

        AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[i]) |-> $past(wr_en && !wr_sel && wr_data[i])); // R8

        AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flags[i]); // R10
    end
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_en   (edge_en),
    .cpu_iflag (cpu_iflag),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .flags     (flags),
    .irq_mask  (irq_mask),
    .irq_req   (irq_req),
    .set_vec   (set_vec)
);

// File: tb/edge_irq_ctrl_test.sv
module edge_irq_ctrl_test;
    localparam int N = 12;
    localparam logic [N-1:0] RISE = 12'h733;
    localparam logic [N-1:0] IDLE = ~RISE;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_in = IDLE;
    logic [N-1:0] edge_en = '1;
    logic         cpu_iflag = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] flags;
    logic [N-1:0] irq_mask;
    logic         irq_req;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    edge_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .edge_en(edge_en),
        .cpu_iflag(cpu_iflag), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .flags(flags), .irq_mask(irq_mask),
        .irq_req(irq_req)
    );

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [N-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        #(4 * 200000);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        tick(3);
        check("R1 flags in reset", 32'(flags), 0);
        check("R1 mask in reset", 32'(irq_mask), 0);
        check("R1 req in reset", 32'(irq_req), 0);
        rst_n = 1'b1;
        tick(1);
        check("R1 flags after reset", 32'(flags), 0);
        tick(4);
        check("R3 idle-high rise after reset ignored", 32'(flags), 0);

        // sweep every source in both directions
        for (int i = 0; i < N; i++) begin
            string tg;
            logic [N-1:0] bit_i;
            bit_i = N'(1) << i;
            tg = RISE[i] ? "R2" : "R3";
            reg_write(1'b1, bit_i);
            pin_in[i] = ~IDLE[i];
            tick(2);
            check({tg, " latency not early"}, 32'(flags), 0);
            tick(1);
            check({tg, " active edge sets flag"}, 32'(flags), 32'(bit_i));
            check("R6 req with enabled flag", 32'(irq_req), 1);
            cpu_iflag = 1'b1;
            #0.5;
            check("R7 masked req", 32'(irq_req), 0);
            cpu_iflag = 1'b0;
            reg_write(1'b0, bit_i);
            tick(4);
            check("R4 held level no reset of flag", 32'(flags), 0);
            pin_in[i] = IDLE[i];
            tick(4);
            check({tg, " opposite edge ignored"}, 32'(flags), 0);
            check("R6 no req without flag", 32'(irq_req), 0);
        end

        // R5: disabled edges ignored, late enable does not set
        edge_en = '0;
        pin_in = ~IDLE;
        tick(5);
        check("R5 disabled edges ignored", 32'(flags), 0);
        edge_en = '1;
        tick(5);
        check("R5 late enable no stale edge", 32'(flags), 0);
        pin_in = IDLE;
        tick(5);
        check("R2 R3 return edges ignored", 32'(flags), 0);

        // R7: recording while masked
        reg_write(1'b1, '1);
        cpu_iflag = 1'b1;
        pin_in = ~IDLE;
        tick(4);
        check("R7 flags record while masked", 32'(flags), 32'hFFF);
        check("R7 req low while masked", 32'(irq_req), 0);

        // R8: partial clear
        reg_write(1'b0, 12'h0F0);
        check("R8 partial clear", 32'(flags), 32'hF0F);

        // R9: mask load leaves flags
        reg_write(1'b1, 12'h00F);
        check("R9 mask loaded", 32'(irq_mask), 32'h00F);
        check("R9 flags unchanged", 32'(flags), 32'hF0F);
        cpu_iflag = 1'b0;
        #0.5;
        check("R6 req from masked-in flag", 32'(irq_req), 1);
        reg_write(1'b1, 12'h0F0);
        check("R6 no enabled flag no req", 32'(irq_req), 0);

        // R10: edge and clear in the same cycle on source 0 (rising)
        pin_in = IDLE;
        tick(4);
        reg_write(1'b0, '1);
        check("R8 clear all", 32'(flags), 0);
        pin_in[0] = 1'b1;
        tick(2);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 12'h001;
        tick(1);
        wr_en = 1'b0; wr_data = '0;
        check("R10 edge wins over clear", 32'(flags), 32'h001);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule